// File: doc/BRIEF.md
# PCI Type-0 Function Configuration Header

This block is the configuration register space of one PCI endpoint function. It spans 64 doublewords: a fixed 16-dword type-0 header followed by a 48-dword device-specific body. Software reaches it through a small dword-addressed register port that has a request strobe, a write flag, a 6-bit dword index, four byte enables and 32-bit write data. The block answers each request with a one-cycle acknowledge, and that acknowledge carries read data when the request was a read.

Parameters fix the identity fields: vendor, device, revision, class code, subsystem IDs, multi-function flag, interrupt pin, grant and latency hints, and capabilities pointer. They also fix the size of each of the six base address registers (BARs). Only a few fields hold state: the command bits, cache line size, latency timer, interrupt line and the address bits of the implemented BARs. Every other location either returns a fixed value or reads as zero.

The port is run by a three-state access machine. In `S_IDLE` it waits for a request. On a request with the write flag set it applies the write in the same cycle and moves to `S_WR_ACK`. On a request without the write flag it captures the read value and moves to `S_RD_RESP`. Both response states return to `S_IDLE` after one cycle, whatever the inputs are.

Top module: `cfg_hdr_space`

## Requirements
- R1: A request is accepted only in `S_IDLE`. `ack` is high during exactly the one cycle after the accepting clock edge. A request presented while a response is in progress is ignored.
- R2: `rdata` is zero in every cycle except the acknowledge cycle of a read. A write acknowledge also returns zero.
- R3: Dword 0 reads `{DEVICE_ID, VENDOR_ID}` (vendor in bits 15:0). Dword 2 reads `{CLASS_CODE, REVISION_ID}` (revision in bits 7:0, class code in bits 31:8). Dword 11 reads `{SUBSYS_ID, SUBSYS_VENDOR_ID}`. Writes to these dwords have no effect.
- R4: Dword 3 reads cache line size in bits 7:0 and latency timer in bits 15:8, and both are writable. Bits 23:16 hold the header-type byte `{MULTI_FUNC, 7'h00}`, with the flag in bit 23 and format 0. BIST in bits 31:24 reads zero.
- R5: Command in dword 1 bits 15:0 is writable only in the bits of mask 0x0547 (bits 0, 1, 2, 6, 8, 10); its other bits read zero. Status in bits 31:16 reads 0x0010 when `CAP_PTR` is nonzero and 0 otherwise. Writes to status are ignored.
- R6: On a write, `be[n]` lets `wdata[8n+7:8n]` update lane n of a writable register. A lane whose enable is low keeps its previous value.
- R7: BAR k sits at dword 4+k, and its size is 2^L with L = `BAR_LOG2[5k+4:5k]`. Bits L-1:0 read zero, and bits 3:0 read zero in every case (memory type, 32-bit, non-prefetchable). Bits 31:L are writable, so writing all ones reads back the size mask. When L is 0 the BAR is unimplemented: it reads zero and ignores writes.
- R8: Dword 13 reads `CAP_PTR` in bits 7:0 and zero elsewhere. Dword 15 holds a writable interrupt line in bits 7:0; interrupt pin (15:8), minimum grant (23:16) and maximum latency (31:24) are read-only.
- R9: Dwords 10, 12 and 14 and all body dwords 16 through 63 read zero, and writes to them have no effect.
- R10: While `rst_n` is low, `ack` and `rdata` are zero. Reset clears every writable field, including the BARs, to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Dword index 0..63 |
| be | input | 4 | Byte lane enables for writes |
| wdata | input | 32 | Write data |
| ack | output | 1 | One-cycle access acknowledge |
| rdata | output | 32 | Read data, valid with `ack` after a read |

## Verification
The assertions assume that `req`, `we`, `addr`, `be` and `wdata` are stable around each rising edge. They also assume that reset is held for at least one edge before any access is made. The bench drives all inputs one time unit after the edge and compares the outputs in that same window, so every input is settled well before the next sampling edge. The stimulus deliberately holds `req` high through response cycles, so that the ignore rule is exercised and not merely avoided. It also uses every byte-enable pattern and addresses spread over the whole 64-dword range.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int DW_ADDR_W   = 6;
    localparam int DATA_W      = 32;
    localparam int LANES       = DATA_W / 8;
    localparam int NUM_BARS    = 6;
    localparam int BAR_LOG2_W  = 5;
    localparam int BAR_BASE_DW = 4;

    localparam logic [DW_ADDR_W-1:0] DW_IDENT   = 6'd0;
    localparam logic [DW_ADDR_W-1:0] DW_CMDSTAT = 6'd1;
    localparam logic [DW_ADDR_W-1:0] DW_CLASS   = 6'd2;
    localparam logic [DW_ADDR_W-1:0] DW_MISC    = 6'd3;
    localparam logic [DW_ADDR_W-1:0] DW_SUBSYS  = 6'd11;
    localparam logic [DW_ADDR_W-1:0] DW_CAPPTR  = 6'd13;
    localparam logic [DW_ADDR_W-1:0] DW_INTR    = 6'd15;

    localparam logic [DATA_W-1:0] CMD_WMASK  = 32'h0000_0547;
    localparam logic [DATA_W-1:0] MISC_WMASK = 32'h0000_FFFF;
    localparam logic [DATA_W-1:0] INTR_WMASK = 32'h0000_00FF;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_RD_RESP = 2'd1,
        S_WR_ACK  = 2'd2
    } acc_state_t;

    typedef struct packed {
        logic                 wr;
        logic [DW_ADDR_W-1:0] dw;
        logic [LANES-1:0]     be;
        logic [DATA_W-1:0]    data;
    } wr_cmd_t;

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [LANES-1:0]  be_v
    );
        logic [DATA_W-1:0] res;
        res = old_v;
        for (int i = 0; i < LANES; i++) begin
            if (be_v[i]) res[i*8 +: 8] = new_v[i*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/cfg_access_fsm.sv
module cfg_access_fsm
    import cfg_hdr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 we,
    input  logic [DW_ADDR_W-1:0] addr,
    input  logic [LANES-1:0]     be,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W-1:0]    rd_mux,
    output wr_cmd_t              wr,
    output logic                 ack,
    output logic [DATA_W-1:0]    rdata
);

    acc_state_t        state_q, state_d;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req) state_d = we ? S_WR_ACK : S_RD_RESP;
            S_RD_RESP: state_d = S_IDLE;
            S_WR_ACK:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                rdata_q <= '0;
        else if (state_q == S_IDLE && req && !we)  rdata_q <= rd_mux;
    end

    always_comb begin
        wr    = '0;
        ack   = 1'b0;
        rdata = '0;
        unique case (state_q)
            S_IDLE: begin
                wr.wr   = req && we;
                wr.dw   = addr;
                wr.be   = be;
                wr.data = wdata;
            end
            S_RD_RESP: begin
                ack   = 1'b1;
                rdata = rdata_q;
            end
            S_WR_ACK: ack = 1'b1;
            default: ;
        endcase
    end

    p_accept_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req) |=> ack);

    p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

endmodule

// File: rtl/cfg_masked_reg.sv
module cfg_masked_reg
    import cfg_hdr_pkg::*;
#(
    parameter logic [DW_ADDR_W-1:0] DW_INDEX = '0,
    parameter logic [DATA_W-1:0]    WMASK    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_cmd_t           wr,
    output logic [DATA_W-1:0] q
);

    logic              hit;
    logic [DATA_W-1:0] merged;

    always_comb begin
        hit    = wr.wr && (wr.dw == DW_INDEX);
        merged = lane_merge(q, wr.data, wr.be) & WMASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= merged;
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr.wr && wr.dw == DW_INDEX) |=> $stable(q));

endmodule

// File: rtl/cfg_bar_bank.sv
module cfg_bar_bank
    import cfg_hdr_pkg::*;
#(
    parameter logic [NUM_BARS*BAR_LOG2_W-1:0] BAR_LOG2 = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  wr_cmd_t                    wr,
    output logic [NUM_BARS*DATA_W-1:0] bar_rd
);

    for (genvar k = 0; k < NUM_BARS; k++) begin : g_bar
        localparam int L = int'(BAR_LOG2[k*BAR_LOG2_W +: BAR_LOG2_W]);
        localparam logic [DW_ADDR_W-1:0] IDX = DW_ADDR_W'(BAR_BASE_DW + k);
        if (L == 0) begin : g_absent
            assign bar_rd[k*DATA_W +: DATA_W] = '0;
        end else begin : g_present
            localparam logic [DATA_W-1:0] BMASK =
                ~((32'h1 << L) - 32'h1) & 32'hFFFF_FFF0;
            logic [DATA_W-1:0] bar_q;
            cfg_masked_reg #(.DW_INDEX(IDX), .WMASK(BMASK)) u_bar (
                .clk  (clk),
                .rst_n(rst_n),
                .wr   (wr),
                .q    (bar_q)
            );
            assign bar_rd[k*DATA_W +: DATA_W] = bar_q;

            p_bar_attr_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (bar_q & ~BMASK) == '0);
        end
    end

endmodule

// File: rtl/cfg_hdr_space.sv
module cfg_hdr_space
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID        = 16'h1AB7,
    parameter logic [15:0] DEVICE_ID        = 16'h4C21,
    parameter logic [7:0]  REVISION_ID      = 8'h03,
    parameter logic [23:0] CLASS_CODE       = 24'h020000,
    parameter logic [15:0] SUBSYS_VENDOR_ID = 16'h1AB7,
    parameter logic [15:0] SUBSYS_ID        = 16'h0101,
    parameter logic        MULTI_FUNC       = 1'b1,
    parameter logic [7:0]  INT_PIN          = 8'h01,
    parameter logic [7:0]  MIN_GNT          = 8'h04,
    parameter logic [7:0]  MAX_LAT          = 8'h18,
    parameter logic [7:0]  CAP_PTR          = 8'h40,
    parameter logic [29:0] BAR_LOG2         = {5'd4, 5'd0, 5'd20, 5'd0, 5'd8, 5'd12}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [5:0]  addr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic        ack,
    output logic [31:0] rdata
);

    localparam logic [15:0] STATUS_RO = (CAP_PTR != 8'h00) ? 16'h0010 : 16'h0000;
    localparam logic [7:0]  HDR_TYPE  = {MULTI_FUNC, 7'h00};

    wr_cmd_t                    wr;
    logic [DATA_W-1:0]          rd_mux;
    logic [DATA_W-1:0]          cmd_q, misc_q, intr_q;
    logic [NUM_BARS*DATA_W-1:0] bar_rd;

    cfg_access_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .we    (we),
        .addr  (addr),
        .be    (be),
        .wdata (wdata),
        .rd_mux(rd_mux),
        .wr    (wr),
        .ack   (ack),
        .rdata (rdata)
    );

    cfg_masked_reg #(.DW_INDEX(DW_CMDSTAT), .WMASK(CMD_WMASK)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr(wr), .q(cmd_q)
    );

    cfg_masked_reg #(.DW_INDEX(DW_MISC), .WMASK(MISC_WMASK)) u_misc (
        .clk(clk), .rst_n(rst_n), .wr(wr), .q(misc_q)
    );

    cfg_masked_reg #(.DW_INDEX(DW_INTR), .WMASK(INTR_WMASK)) u_intr (
        .clk(clk), .rst_n(rst_n), .wr(wr), .q(intr_q)
    );

    cfg_bar_bank #(.BAR_LOG2(BAR_LOG2)) u_bars (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr),
        .bar_rd(bar_rd)
    );

    always_comb begin
        rd_mux = '0;
        case (addr)
            DW_IDENT:   rd_mux = {DEVICE_ID, VENDOR_ID};
            DW_CMDSTAT: rd_mux = {STATUS_RO, 16'h0000} | cmd_q;
            DW_CLASS:   rd_mux = {CLASS_CODE, REVISION_ID};
            DW_MISC:    rd_mux = {8'h00, HDR_TYPE, 16'h0000} | misc_q;
            DW_SUBSYS:  rd_mux = {SUBSYS_ID, SUBSYS_VENDOR_ID};
            DW_CAPPTR:  rd_mux = {24'h0, CAP_PTR};
            DW_INTR:    rd_mux = {MAX_LAT, MIN_GNT, INT_PIN, 8'h00} | intr_q;
            default:    rd_mux = '0;
        endcase
        for (int k = 0; k < NUM_BARS; k++) begin
            if (addr == DW_ADDR_W'(BAR_BASE_DW + k)) rd_mux = bar_rd[k*DATA_W +: DATA_W];
        end
    end

    p_rdata_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> (rdata == '0));

    p_no_write_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !wr.wr);

endmodule

// File: tb/cfg_hdr_space_tb_top.sv
module cfg_hdr_space_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [15:0] P_VEN  = 16'h1AB7;
    localparam logic [15:0] P_DEV  = 16'h4C21;
    localparam logic [7:0]  P_REV  = 8'h03;
    localparam logic [23:0] P_CLS  = 24'h020000;
    localparam logic [15:0] P_SSV  = 16'h1AB7;
    localparam logic [15:0] P_SSI  = 16'h0101;
    localparam logic        P_MF   = 1'b1;
    localparam logic [7:0]  P_PIN  = 8'h01;
    localparam logic [7:0]  P_GNT  = 8'h04;
    localparam logic [7:0]  P_LAT  = 8'h18;
    localparam logic [7:0]  P_CAP  = 8'h40;
    localparam int          BAR_L [6] = '{12, 8, 0, 20, 0, 4};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic        ack;
    logic [31:0] rdata;

    int    n_vec = 0;
    int    n_bad = 0;
    string tag = "R10";

    // reference state
    bit          m_busy = 0;
    logic [15:0] m_cmd = 0;
    logic [7:0]  m_cache = 0, m_lat = 0, m_intl = 0;
    logic [31:0] m_bar [6] = '{default: 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_hdr_space #(
        .VENDOR_ID(P_VEN), .DEVICE_ID(P_DEV), .REVISION_ID(P_REV),
        .CLASS_CODE(P_CLS), .SUBSYS_VENDOR_ID(P_SSV), .SUBSYS_ID(P_SSI),
        .MULTI_FUNC(P_MF), .INT_PIN(P_PIN), .MIN_GNT(P_GNT), .MAX_LAT(P_LAT),
        .CAP_PTR(P_CAP),
        .BAR_LOG2({5'd4, 5'd0, 5'd20, 5'd0, 5'd8, 5'd12})
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .be(be), .wdata(wdata), .ack(ack), .rdata(rdata)
    );

    function automatic logic [31:0] bar_mask(int k);
        if (BAR_L[k] == 0) return 32'h0;
        return ~((32'h1 << BAR_L[k]) - 32'h1) & 32'hFFFF_FFF0;
    endfunction

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] b);
        logic [31:0] r = o;
        for (int i = 0; i < 4; i++) if (b[i]) r[i*8 +: 8] = n[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] m_read(logic [5:0] a);
        if (a >= 4 && a <= 9) return m_bar[a-4];
        case (a)
            0:  return {P_DEV, P_VEN};
            1:  return {(P_CAP != 0) ? 16'h0010 : 16'h0, m_cmd};
            2:  return {P_CLS, P_REV};
            3:  return {8'h00, P_MF, 7'h00, m_lat, m_cache};
            11: return {P_SSI, P_SSV};
            13: return {24'h0, P_CAP};
            15: return {P_LAT, P_GNT, P_PIN, m_intl};
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_write(logic [5:0] a, logic [3:0] b, logic [31:0] d);
        logic [31:0] t;
        if (a >= 4 && a <= 9) begin
            m_bar[a-4] = merge(m_bar[a-4], d, b) & bar_mask(a-4);
        end else if (a == 1) begin
            t = merge({16'h0, m_cmd}, d, b);
            m_cmd = t[15:0] & 16'h0547;
        end else if (a == 3) begin
            t = merge({16'h0, m_lat, m_cache}, d, b);
            m_cache = t[7:0];
            m_lat   = t[15:8];
        end else if (a == 15) begin
            t = merge({24'h0, m_intl}, d, b);
            m_intl = t[7:0];
        end
    endtask

    // one clock: advance reference on the edge, compare shortly after
    task automatic step();
        bit          acc;
        logic [31:0] exp_rd;
        @(posedge clk);
        acc    = rst_n && !m_busy && req;
        exp_rd = 32'h0;
        if (acc) begin
            if (we) m_write(addr, be, wdata);
            else    exp_rd = m_read(addr);
        end
        m_busy = acc;
        #1;
        n_vec++;
        if (ack !== acc || rdata !== exp_rd) begin
            n_bad++;
            $display("FAIL %s: ack=%0b rdata=%08h expected ack=%0b rdata=%08h (addr=%0d we=%0b)",
                     tag, ack, rdata, acc, exp_rd, addr, we);
        end
    endtask

    task automatic rd(logic [5:0] a);
        req = 1; we = 0; addr = a; be = 4'h0; wdata = $urandom;
        step();
        req = 0;
        step();
    endtask

    task automatic wrt(logic [5:0] a, logic [3:0] b, logic [31:0] d);
        req = 1; we = 1; addr = a; be = b; wdata = d;
        step();
        req = 0;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R10: reset holds outputs quiet even with a request present
        tag = "R10"; req = 1; we = 0; addr = 6'd0;
        repeat (3) step();
        req = 0;
        #(CLK_PERIOD/2);
        rst_n = 1;
        step();
        for (int a = 0; a < 16; a++) rd(6'(a));   // R10 reset values

        tag = "R3";
        wrt(0, 4'hF, 32'hFFFF_FFFF); rd(0);
        wrt(2, 4'hF, 32'h1234_5678); rd(2);
        wrt(11, 4'hF, 32'h0); rd(11);

        tag = "R4";
        wrt(3, 4'hF, 32'hFFFF_FFFF); rd(3);
        wrt(3, 4'h1, 32'h0000_0010); rd(3);

        tag = "R5";
        wrt(1, 4'hF, 32'hFFFF_FFFF); rd(1);
        wrt(1, 4'h3, 32'h0000_0002); rd(1);

        tag = "R6";
        wrt(1, 4'h2, 32'h0000_0000); rd(1);
        wrt(3, 4'h2, 32'h0000_AB00); rd(3);
        wrt(15, 4'hE, 32'hFFFF_FF00); rd(15);

        tag = "R7";
        for (int k = 0; k < 6; k++) begin
            wrt(6'(4 + k), 4'hF, 32'hFFFF_FFFF); rd(6'(4 + k));
            wrt(6'(4 + k), 4'hC, 32'hA5C3_0000); rd(6'(4 + k));
        end

        tag = "R8";
        wrt(15, 4'hF, 32'h1122_3344); rd(15);
        wrt(13, 4'hF, 32'hFFFF_FFFF); rd(13);

        tag = "R9";
        for (int a = 10; a < 64; a++) begin
            if (a == 10 || a == 12 || a == 14 || a >= 16) begin
                wrt(6'(a), 4'hF, 32'hDEAD_BEEF); rd(6'(a));
            end
        end

        tag = "R1";   // request held high through the response cycle
        req = 1; we = 0; addr = 6'd15;
        repeat (5) step();
        req = 1; we = 1; addr = 6'd15; be = 4'h1; wdata = 32'h0000_0077;
        repeat (4) step();
        req = 0;
        step();
        rd(15);

        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            req   = ($urandom % 4) != 0;
            we    = $urandom % 2;
            addr  = (($urandom % 3) == 0) ? 6'($urandom % 64) : 6'($urandom % 16);
            be    = 4'($urandom);
            wdata = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom;
            step();
        end
        req = 0;
        step();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule